// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting channel of a multi-channel interval timer. A one-cycle count-enable pulse (`tick`) advances it. Around it, other logic decodes the bus, holds the control word and assembles the count bytes. That logic hands the channel three things: a mode number with a binary/decimal select, a new initial count, and a gate level. The channel drives a single output waveform and shows its live count for a readback path.

Six operating modes are offered. Mode 0 asserts the output at terminal count. Mode 1 is a one-shot started by the gate. Mode 2 is a divide-by-N rate generator. Mode 3 is a square-wave generator. Mode 4 gives a strobe started by software, and mode 5 gives a strobe started by the gate. Each mode has its own rule for how the gate acts and for what happens at terminal count: the periodic modes reload, and the others wrap and keep counting. Counting is either 16-bit binary or four-digit decimal, with each nibble holding one digit.

Top module: `ivc_channel`

## Requirements
- R1: While reset is active and after it is released, `out_o` is 1 and `count_o` is 0, and ticks change nothing until a mode and a count have been written.
- R2: On a config write, `out_o` becomes 0 at the next clock edge for mode 0 and 1 for any other mode, and counting halts until a new count arrives. Mode codes 6 and 7 behave as modes 2 and 3.
- R3: A programmed count of 0 stands for 65536 in binary and 10000 in decimal. After it is loaded, the next decrement gives 16'hFFFF or 16'h9999 respectively.
- R4: In mode 0, a count write drives `out_o` to 0 and the count loads on the next tick. After N further ticks with the gate high, `out_o` is 1 and stays at 1. The counter wraps and keeps counting.
- R5: In modes 0 and 4, a low gate freezes the count. A rising gate edge does not reload the count.
- R6: In mode 1, a count write alone starts nothing. The first tick after a rising gate edge loads N and drives `out_o` to 0, and `out_o` returns to 1 after N more ticks. A later rising edge restarts the cycle.
- R7: In mode 2 with count N≥2, the count runs N, N-1, …, 1 and then reloads. `out_o` is 0 only during the tick interval in which the count is 1.
- R8: In mode 3 with count N≥2, `out_o` is 1 for (N+1)/2 ticks and 0 for N/2 ticks of every period. The count steps down by 2 and is always even.
- R9: In mode 4, `out_o` stays 1 after a load and drops to 0 for exactly one tick interval when the count reaches 0. This happens once per load.
- R10: Mode 5 produces the same single strobe as mode 4, but each rising gate edge starts or restarts it.
- R11: In modes 2 and 3, a low gate forces `out_o` to 1 at the next clock edge and stops counting. The first tick after the gate rises reloads the initial count.
- R12: When the decimal select is set, the count decrements in decimal digits, with borrows across nibbles, for example 16'h1000 to 16'h0999.
- R13: `out_o` and `count_o` change only on clock edges that carry a tick, a config write, a count write, or (in modes 2 and 3) a gate change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count-enable pulse, one clock wide |
| cfg_we | input | 1 | Config write strobe |
| cfg_mode | input | 3 | Mode number 0..7 (6 and 7 alias 2 and 3) |
| cfg_bcd | input | 1 | 1 selects decimal counting |
| cnt_we | input | 1 | Initial-count write strobe |
| cnt_val | input | 16 | Initial count |
| gate | input | 1 | Gate level |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Live count value |

## Verification
Errors in the count register show up on `count_o` at the very tick where they occur. For that reason every sweep compares the count after each tick against arithmetic expectations, and does not only time the output edges. A wrong phase or strobe flag does not show on the count. It appears as an output edge one tick early or late, or as a second strobe after wraparound, so the output is sampled at every tick for several full periods. A gate edge that is lost or latched twice shows up on the first tick after the gate rises.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ivc_mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic ivc_mode_e norm_mode(input logic [2:0] m);
    if (m[2:1] == 2'b11) return ivc_mode_e'({1'b0, m[1:0]});
    return ivc_mode_e'(m);
  endfunction

endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/ivc_gate_edge.sv
module ivc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic tick,
  input  logic clr,
  output logic trig_o
);

  logic gate_q;
  logic trig_q, trig_d;
  logic rise;

  assign rise   = gate & ~gate_q;
  assign trig_o = trig_q | rise;

  always_comb begin
    trig_d = trig_q | rise;
    if (clr || tick) trig_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      gate_q <= gate;
      trig_q <= trig_d;
    end
  end

endmodule

// File: rtl/ivc_bcd_step.sv
module ivc_bcd_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         bcd,
  input  logic         sub,
  input  logic [1:0]   mag,
  output logic [W-1:0] y
);

  localparam int ND = W / 4;

  logic [W-1:0] bin_y;
  logic [W-1:0] dec_y;
  logic [1:0]   carry [ND];

  assign carry[0] = mag;
  assign bin_y = sub ? (a - {{(W-2){1'b0}}, mag}) : (a + {{(W-2){1'b0}}, mag});

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [3:0] d;
    logic [5:0] t;
    logic [3:0] r;

    assign d = a[4*g +: 4];
    assign t = sub ? ({2'b00, d} - {4'b0000, carry[g]})
                   : ({2'b00, d} + {4'b0000, carry[g]});

    always_comb begin
      if (sub) r = t[5] ? (t[3:0] + 4'd10) : t[3:0];
      else     r = (t > 6'd9) ? (t[3:0] - 4'd10) : t[3:0];
    end

    assign dec_y[4*g +: 4] = r;

    if (g < ND - 1) begin : g_c
      assign carry[g+1] = {1'b0, sub ? t[5] : (t > 6'd9)};
    end
  end

  assign y = bcd ? dec_y : bin_y;

endmodule

// File: rtl/ivc_channel.sv
module ivc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_bcd,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             gate,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  import ivc_pkg::*;

  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);

  logic rst_n_s;
  logic trig;

  ivc_mode_e        mode_q, mode_d;
  logic             bcd_q, bcd_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ld_pend_q, ld_pend_d;
  logic             armed_q, armed_d;
  logic             run_q, run_d;
  logic             out_q, out_d;
  logic             fired_q, fired_d;

  logic [CNT_W-1:0] cnt_dec, init_up, init_dn;
  logic [CNT_W-1:0] hi_start, lo_start;
  logic [1:0]       dec_mag;
  ivc_mode_e        cfg_norm;

  ivc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  ivc_gate_edge u_gate (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .gate   (gate),
    .tick   (tick),
    .clr    (cfg_we),
    .trig_o (trig)
  );

  assign dec_mag = (mode_q == MD_SQUARE) ? 2'd2 : 2'd1;

  ivc_bcd_step #(.W(CNT_W)) u_dec (
    .a(cnt_q), .bcd(bcd_q), .sub(1'b1), .mag(dec_mag), .y(cnt_dec)
  );
  ivc_bcd_step #(.W(CNT_W)) u_up (
    .a(init_q), .bcd(bcd_q), .sub(1'b0), .mag(2'd1), .y(init_up)
  );
  ivc_bcd_step #(.W(CNT_W)) u_dn (
    .a(init_q), .bcd(bcd_q), .sub(1'b1), .mag(2'd1), .y(init_dn)
  );

  // square-wave half periods: odd counts give the extra tick to the high half
  assign hi_start = init_q[0] ? init_up : init_q;
  assign lo_start = init_q[0] ? init_dn : init_q;
  assign cfg_norm = norm_mode(cfg_mode);

  always_comb begin
    mode_d    = mode_q;
    bcd_d     = bcd_q;
    init_d    = init_q;
    cnt_d     = cnt_q;
    ld_pend_d = ld_pend_q;
    armed_d   = armed_q;
    run_d     = run_q;
    out_d     = out_q;
    fired_d   = fired_q;

    if (cfg_we) begin
      mode_d    = cfg_norm;
      bcd_d     = cfg_bcd;
      run_d     = 1'b0;
      ld_pend_d = 1'b0;
      armed_d   = 1'b0;
      fired_d   = 1'b0;
      out_d     = (cfg_norm != MD_TERM);
    end else begin
      if (cnt_we) begin
        init_d = cnt_val;
        case (mode_q)
          MD_ONESHOT, MD_HWSTROBE: armed_d = 1'b1;
          MD_TERM: begin
            ld_pend_d = 1'b1;
            out_d     = 1'b0;
          end
          default: ld_pend_d = 1'b1;
        endcase
      end

      if (tick) begin
        case (mode_q)
          MD_TERM, MD_SWSTROBE: begin
            if (mode_q == MD_SWSTROBE) out_d = 1'b1;
            if (ld_pend_q) begin
              cnt_d     = init_q;
              run_d     = 1'b1;
              ld_pend_d = 1'b0;
              fired_d   = 1'b0;
              out_d     = (mode_q == MD_SWSTROBE);
            end else if (run_q && gate) begin
              cnt_d = cnt_dec;
              if (cnt_q == C_ONE) begin
                if (mode_q == MD_TERM) begin
                  out_d = 1'b1;
                end else if (!fired_q) begin
                  out_d   = 1'b0;
                  fired_d = 1'b1;
                end
              end
            end
          end
          MD_ONESHOT, MD_HWSTROBE: begin
            if (mode_q == MD_HWSTROBE) out_d = 1'b1;
            if (trig && armed_q) begin
              cnt_d   = init_q;
              run_d   = 1'b1;
              fired_d = 1'b0;
              out_d   = (mode_q == MD_HWSTROBE);
            end else if (run_q) begin
              cnt_d = cnt_dec;
              if (cnt_q == C_ONE) begin
                if (mode_q == MD_ONESHOT) begin
                  out_d = 1'b1;
                end else if (!fired_q) begin
                  out_d   = 1'b0;
                  fired_d = 1'b1;
                end
              end
            end
          end
          default: begin
            if (gate) begin
              if (ld_pend_q || (trig && run_q)) begin
                cnt_d     = (mode_q == MD_SQUARE) ? hi_start : init_q;
                out_d     = 1'b1;
                run_d     = 1'b1;
                ld_pend_d = 1'b0;
              end else if (run_q) begin
                if (mode_q == MD_RATE) begin
                  if (cnt_q == C_ONE) begin
                    cnt_d = init_q;
                    out_d = 1'b1;
                  end else begin
                    cnt_d = cnt_dec;
                    out_d = (cnt_q != C_TWO);
                  end
                end else begin
                  if (cnt_q == C_TWO) begin
                    cnt_d = out_q ? lo_start : hi_start;
                    out_d = ~out_q;
                  end else begin
                    cnt_d = cnt_dec;
                  end
                end
              end
            end
          end
        endcase
      end

      if (((mode_q == MD_RATE) || (mode_q == MD_SQUARE)) && !gate) out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q    <= MD_TERM;
      bcd_q     <= 1'b0;
      init_q    <= '0;
      cnt_q     <= '0;
      ld_pend_q <= 1'b0;
      armed_q   <= 1'b0;
      run_q     <= 1'b0;
      out_q     <= 1'b1;
      fired_q   <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      bcd_q     <= bcd_d;
      init_q    <= init_d;
      cnt_q     <= cnt_d;
      ld_pend_q <= ld_pend_d;
      armed_q   <= armed_d;
      run_q     <= run_d;
      out_q     <= out_d;
      fired_q   <= fired_d;
    end
  end

  assign out_o   = out_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/ivc_channel_chk.sv
module ivc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cfg_we,
  input logic [2:0]       cfg_mode,
  input logic             cnt_we,
  input logic             gate,
  input logic             out_o,
  input logic [CNT_W-1:0] count_o,
  input logic [2:0]       mode_q,
  input logic             run_q
);

  p_cfg_out_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (out_o == ($past(cfg_mode) != 3'd0)));

  p_count_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_o));

  p_out_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we && !cnt_we && $stable(gate)) |=> $stable(out_o));

  p_square_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == 3'd3) |-> !count_o[0]);

  p_term_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out_o && !cfg_we && !cnt_we) |=> out_o);

  p_gate_low_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !cfg_we && (mode_q == 3'd2 || mode_q == 3'd3)) |=> out_o);

endmodule

bind ivc_channel ivc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .tick     (tick),
  .cfg_we   (cfg_we),
  .cfg_mode (cfg_mode),
  .cnt_we   (cnt_we),
  .gate     (gate),
  .out_o    (out_o),
  .count_o  (count_o),
  .mode_q   (mode_q),
  .run_q    (run_q)
);

// File: tb/test_ivc_channel.sv
`timescale 1ns/1ps
module test_ivc_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, cfg_we, cfg_bcd, cnt_we, gate;
  logic [2:0]  cfg_mode;
  logic [15:0] cnt_val;
  logic        out_o;
  logic [15:0] count_o;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  ivc_channel #(.CNT_W(16)) i_ivc_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_bcd(cfg_bcd), .cnt_we(cnt_we), .cnt_val(cnt_val), .gate(gate),
    .out_o(out_o), .count_o(count_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] m, input logic b);
    @(negedge clk) begin cfg_we = 1'b1; cfg_mode = m; cfg_bcd = b; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic wcnt(input logic [15:0] v);
    @(negedge clk) begin cnt_we = 1'b1; cnt_val = v; end
    @(negedge clk) cnt_we = 1'b0;
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk) gate = g;
    @(negedge clk);
  endtask

  function automatic logic [15:0] bcd_enc(input int v);
    return 16'(((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10));
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] prev;
    rst_n = 1'b0; tick = 0; cfg_we = 0; cfg_bcd = 0; cnt_we = 0; gate = 1'b1;
    cfg_mode = 3'd0; cnt_val = 16'd0;
    repeat (4) @(negedge clk);
    chk("R1 out in reset", out_o, 1);
    chk("R1 count in reset", count_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out after reset", out_o, 1);
    for (int i = 0; i < 3; i++) do_tick();
    chk("R1 idle count", count_o, 0);
    chk("R1 idle out", out_o, 1);

    // R4 sweep of mode 0
    for (int n = 1; n <= 12; n++) begin
      cfg(3'd0, 1'b0);
      chk("R2 mode0 out low", out_o, 0);
      do_tick();
      chk("R2 no count no load", count_o, (n == 1) ? 16'd0 : 16'hFFFF);
      wcnt(16'(n));
      do_tick();
      chk("R4 load", count_o, n);
      chk("R4 out after load", out_o, 0);
      for (int k = 1; k <= n; k++) begin
        do_tick();
        chk("R4 count", count_o, 16'(n - k));
        chk("R4 out", out_o, (k == n) ? 1 : 0);
      end
      do_tick();
      chk("R4 wrap count", count_o, 16'hFFFF);
      chk("R4 out sticky", out_o, 1);
    end

    // R5 gate in mode 0
    cfg(3'd0, 1'b0); wcnt(16'd5);
    for (int i = 0; i < 3; i++) do_tick();
    chk("R5 before gate", count_o, 3);
    set_gate(1'b0);
    for (int i = 0; i < 3; i++) do_tick();
    chk("R5 frozen", count_o, 3);
    set_gate(1'b1);
    do_tick();
    chk("R5 no reload on rise", count_o, 2);

    // R3 zero count
    cfg(3'd0, 1'b0); wcnt(16'd0); do_tick();
    chk("R3 bin load", count_o, 0);
    do_tick();
    chk("R3 bin wrap", count_o, 16'hFFFF);
    chk("R3 bin not terminal", out_o, 0);
    cfg(3'd0, 1'b1); wcnt(16'd0); do_tick(); do_tick();
    chk("R3 bcd wrap", count_o, 16'h9999);

    // R12 decimal sweep
    cfg(3'd0, 1'b1); wcnt(16'h0123); do_tick();
    for (int k = 1; k <= 40; k++) begin
      do_tick();
      chk("R12 bcd count", count_o, bcd_enc(123 - k));
    end
    wcnt(16'h1000); do_tick(); do_tick();
    chk("R12 bcd borrow", count_o, 16'h0999);

    // R6 mode 1
    cfg(3'd1, 1'b0);
    set_gate(1'b0);
    prev = count_o;
    wcnt(16'd4);
    for (int i = 0; i < 3; i++) do_tick();
    chk("R6 no start without gate", count_o, prev);
    chk("R6 out idle", out_o, 1);
    set_gate(1'b1);
    do_tick();
    chk("R6 load", count_o, 4);
    chk("R6 out low", out_o, 0);
    for (int k = 1; k <= 4; k++) begin
      do_tick();
      chk("R6 count", count_o, 16'(4 - k));
      chk("R6 out", out_o, (k == 4) ? 1 : 0);
    end
    do_tick(); do_tick();
    chk("R6 wrap", count_o, 16'hFFFE);
    set_gate(1'b0); set_gate(1'b1);
    do_tick();
    chk("R6 retrigger count", count_o, 4);
    chk("R6 retrigger out", out_o, 0);

    // R7 mode 2 sweep
    for (int n = 2; n <= 9; n++) begin
      cfg(3'd2, 1'b0); wcnt(16'(n)); do_tick();
      chk("R7 load", count_o, n);
      chk("R7 out load", out_o, 1);
      for (int k = 1; k <= 3 * n; k++) begin
        do_tick();
        chk("R7 count", count_o, ((k % n) == 0) ? n : n - (k % n));
        chk("R7 out", out_o, ((k % n) == n - 1) ? 0 : 1);
      end
    end
    for (int i = 0; i < 8; i++) do_tick();
    chk("R7 at one", out_o, 0);
    set_gate(1'b0);
    chk("R11 gate low out", out_o, 1);
    for (int i = 0; i < 3; i++) do_tick();
    chk("R11 frozen", count_o, 1);
    set_gate(1'b1);
    do_tick();
    chk("R11 reload", count_o, 9);

    // R2 alias code 6 acts as mode 2
    cfg(3'd6, 1'b0); wcnt(16'd3); do_tick();
    do_tick(); do_tick();
    chk("R2 alias count", count_o, 1);
    chk("R2 alias out", out_o, 0);
    do_tick();
    chk("R2 alias reload", count_o, 3);

    // R8 mode 3 sweep
    for (int n = 2; n <= 11; n++) begin
      int h, l;
      h = (n + 1) / 2;
      l = n / 2;
      cfg(3'd3, 1'b0); wcnt(16'(n)); do_tick();
      for (int t = 0; t <= 3 * n; t++) begin
        int p;
        if (t > 0) do_tick();
        p = t % n;
        chk("R8 out", out_o, (p < h) ? 1 : 0);
        chk("R8 count", count_o, (p < h) ? 2 * h - 2 * p : 2 * l - 2 * (p - h));
      end
    end
    set_gate(1'b0);
    chk("R11 square gate low", out_o, 1);
    set_gate(1'b1);
    do_tick();
    chk("R11 square reload", count_o, 12);

    // R9 mode 4
    cfg(3'd4, 1'b0);
    chk("R9 out after cfg", out_o, 1);
    wcnt(16'd3); do_tick();
    chk("R9 load", count_o, 3);
    for (int k = 1; k <= 3; k++) begin
      do_tick();
      chk("R9 strobe", out_o, (k == 3) ? 0 : 1);
    end
    do_tick();
    chk("R9 strobe end", out_o, 1);
    chk("R9 wrap", count_o, 16'hFFFF);
    for (int i = 0; i < 3; i++) begin
      do_tick();
      chk("R9 single strobe", out_o, 1);
    end

    // R10 mode 5
    cfg(3'd5, 1'b0);
    prev = count_o;
    wcnt(16'd3); do_tick();
    chk("R10 wait for gate", count_o, prev);
    for (int r = 0; r < 2; r++) begin
      set_gate(1'b0); set_gate(1'b1);
      do_tick();
      chk("R10 load", count_o, 3);
      for (int k = 1; k <= 3; k++) begin
        do_tick();
        chk("R10 strobe", out_o, (k == 3) ? 0 : 1);
      end
      do_tick();
      chk("R10 strobe end", out_o, 1);
    end

    // R13 quiet without ticks
    cfg(3'd2, 1'b0); wcnt(16'd5); do_tick();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R13 count quiet", count_o, 5);
      chk("R13 out quiet", out_o, 1);
    end

    summary();
    $finish;
  end

endmodule